// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block is a small direct-mapped table that remembers where taken branches went. The fetch stage presents the current instruction address on the lookup port and gets back, in the same cycle, a hit flag and a predicted target. On a miss there is no prediction, and fetch simply continues at the next sequential address. When a branch resolves, the update port receives its address, whether it was taken, and its target. The table then installs, refreshes or removes the entry that branch maps to.

The address is cut into three fields. The two lowest bits are a byte offset and are ignored. The next `IDX_W` bits (by default bits 5..2, giving 16 entries) select the entry. All bits above the index form the tag. Each entry holds a valid bit, a tag and a full-width target. A lookup hits only when the selected entry is valid and its tag equals the tag of the lookup address.

Both ports are streams without back-pressure. A beat is transferred whenever its valid input is high, and the block accepts one lookup and one update every cycle. Because of that, neither port has a ready output.

Top module: `btb_direct`

## Requirements
- R1: After reset every entry is empty, so no lookup hits until a taken update has been written.
- R2: The entry index is pc[5:2] and the tag is pc[31:6]. Bits pc[1:0] are ignored, so 0x0000ac27 finds the entry written by 0x0000ac24. Addresses 0x0000ac24 and 0x0000aca4 share entry 9 but carry different tags (0x2b0 and 0x2b2).
- R3: lk_hit is high exactly when lk_valid is high, the selected entry is valid and the stored tag equals the lookup tag. On a hit, lk_target equals the stored target.
- R4: A taken update (upd_valid=1, upd_taken=1) writes its tag and target into its entry. A lookup of the same address hits with that target from the next cycle on.
- R5: A taken update replaces whatever branch previously held its entry. After that, the evicted address misses.
- R6: A not-taken update whose tag matches a valid entry clears that entry, so a later lookup of that address misses.
- R7: A not-taken update whose tag differs from the stored tag leaves that entry unchanged.
- R8: When a lookup and an update select the same entry in the same cycle, the lookup returns the contents as they were before the update.
- R9: An update changes only the entry it indexes. All other entries keep their contents.
- R10: While lk_valid is low, lk_hit is low.
- R11: While upd_valid is low, the table does not change, whatever is on upd_taken, upd_pc and upd_target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; empties the table |
| lk_valid | input | 1 | Lookup beat present |
| lk_pc | input | ADDR_W | Address to look up |
| lk_hit | output | 1 | Entry valid and tag match for this lookup |
| lk_target | output | ADDR_W | Predicted target, meaningful only while lk_hit is high |
| upd_valid | input | 1 | Update beat present |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction: 1 taken, 0 not taken |
| upd_target | input | ADDR_W | Resolved target of a taken branch |

## Verification
The properties assume a single update per cycle. They also assume that a lookup of an address updated in the previous cycle sees no other write to that entry in between. The one update port guarantees both. The persistence property further assumes that a lookup repeated with upd_valid low sees the same entry. The stimulus drives all inputs one time unit after the rising edge and holds them for the whole cycle, so combinational lookups are sampled on settled values. The random phase draws addresses from a small pool of four tags across all sixteen indices, which forces frequent evictions, same-entry collisions and not-taken updates that miss.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam int unsigned BTB_ADDR_W_DEF = 32;
  localparam int unsigned BTB_IDX_W_DEF  = 4;
  localparam int unsigned BTB_OFS_W_DEF  = 2;

  // Action the update controller asks the storage to apply to one entry.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_KILL  = 2'd2
  } upd_act_e;

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OFS_W  = 2,
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  // Byte-offset bits take no part in indexing or tagging.
  logic unused_ofs;
  assign unused_ofs = ^pc[OFS_W-1:0];

  assign idx = pc[OFS_W +: IDX_W];
  assign tag = pc[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/btb_upd_ctrl.sv
module btb_upd_ctrl
  import btb_pkg::*;
#(
  parameter int unsigned TAG_W = 26
) (
  input  logic             upd_valid,
  input  logic             upd_taken,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             cur_valid,
  input  logic [TAG_W-1:0] cur_tag,
  output upd_act_e         act
);

  logic same_branch;
  assign same_branch = cur_valid && (cur_tag == upd_tag);

  always_comb begin
    act = ACT_NONE;
    if (upd_valid) begin
      if (upd_taken) begin
        act = ACT_WRITE;
      end else if (same_branch) begin
        act = ACT_KILL;
      end
    end
  end

endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  wr_idx,
  input  upd_act_e          wr_act,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_tgt,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag
);

  logic [ENTRIES-1:0] vld_all;
  logic [TAG_W-1:0]   tag_all [ENTRIES];
  logic [ADDR_W-1:0]  tgt_all [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              sel;
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] tgt_q;

    assign sel = (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        tag_q <= '0;
        tgt_q <= '0;
      end else if (sel) begin
        case (wr_act)
          ACT_WRITE: begin
            vld_q <= 1'b1;
            tag_q <= wr_tag;
            tgt_q <= wr_tgt;
          end
          ACT_KILL: vld_q <= 1'b0;
          default: ;
        endcase
      end
    end

    assign vld_all[e] = vld_q;
    assign tag_all[e] = tag_q;
    assign tgt_all[e] = tgt_q;
  end

  // Read ports see register outputs, so a same-cycle write is not visible.
  assign ra_valid = vld_all[ra_idx];
  assign ra_tag   = tag_all[ra_idx];
  assign ra_tgt   = tgt_all[ra_idx];
  assign rb_valid = vld_all[rb_idx];
  assign rb_tag   = tag_all[rb_idx];

endmodule

// File: rtl/btb_direct.sv
module btb_direct
  import btb_pkg::*;
#(
  parameter int unsigned ADDR_W = BTB_ADDR_W_DEF,
  parameter int unsigned IDX_W  = BTB_IDX_W_DEF,
  parameter int unsigned OFS_W  = BTB_OFS_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);

  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [IDX_W-1:0]  up_idx;
  logic [TAG_W-1:0]  up_tag;
  logic              ent_v_lk;
  logic [TAG_W-1:0]  ent_tag_lk;
  logic [ADDR_W-1:0] ent_tgt_lk;
  logic              ent_v_up;
  logic [TAG_W-1:0]  ent_tag_up;
  upd_act_e          act;

  btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) lk_split_i (
    .pc (lk_pc),
    .idx(lk_idx),
    .tag(lk_tag)
  );

  btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) up_split_i (
    .pc (upd_pc),
    .idx(up_idx),
    .tag(up_tag)
  );

  btb_upd_ctrl #(.TAG_W(TAG_W)) ctrl_i (
    .upd_valid(upd_valid),
    .upd_taken(upd_taken),
    .upd_tag  (up_tag),
    .cur_valid(ent_v_up),
    .cur_tag  (ent_tag_up),
    .act      (act)
  );

  btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) store_i (
    .clk     (clk),
    .rst     (rst),
    .wr_idx  (up_idx),
    .wr_act  (act),
    .wr_tag  (up_tag),
    .wr_tgt  (upd_target),
    .ra_idx  (lk_idx),
    .ra_valid(ent_v_lk),
    .ra_tag  (ent_tag_lk),
    .ra_tgt  (ent_tgt_lk),
    .rb_idx  (up_idx),
    .rb_valid(ent_v_up),
    .rb_tag  (ent_tag_up)
  );

  assign lk_hit    = lk_valid && ent_v_lk && (ent_tag_lk == lk_tag);
  assign lk_target = ent_tgt_lk;

endmodule

// File: rtl/btb_direct_chk.sv
module btb_direct_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_target,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target
);

  // R1: first cycle out of reset never hits.
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  // R10: no hit without a lookup beat.
  p_hit_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_valid);

  // R4: a taken update is visible to a lookup of the same address next cycle.
  p_taken_visible_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken) ##1 (lk_valid && lk_pc == $past(upd_pc))
      |-> (lk_hit && lk_target == $past(upd_target)));

  // R6: after a not-taken update, that address misses.
  p_not_taken_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken) ##1 (lk_valid && lk_pc == $past(upd_pc))
      |-> !lk_hit);

  // R11: with no update beat, a hit persists unchanged.
  p_idle_keeps_r11: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_hit && !upd_valid) ##1 (lk_valid && lk_pc == $past(lk_pc))
      |-> (lk_hit && $stable(lk_target)));

endmodule

bind btb_direct btb_direct_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/btb_direct_tb_top.sv
module btb_direct_tb_top;

  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_pc = '0;
  logic          lk_hit;
  logic [AW-1:0] lk_target;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;
  logic [AW-1:0] upd_target = '0;

  always #5 clk = ~clk;

  btb_direct dut_i (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_pc     (lk_pc),
    .lk_hit    (lk_hit),
    .lk_target (lk_target),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken),
    .upd_target(upd_target)
  );

  typedef struct {
    bit          hit;
    logic [31:0] tgt;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  // Behavioural table built from the requirements (index pc[5:2], tag pc[31:6]).
  bit          m_v   [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];

  // Driver: drives one cycle of stimulus and pushes the expected lookup result.
  task automatic step(input bit lv, input logic [31:0] lpc,
                      input bit uv, input bit ut, input logic [31:0] upc,
                      input logic [31:0] utg, input string req);
    exp_t e;
    int li, ui;
    @(posedge clk);
    #1;
    lk_valid = lv; lk_pc = lpc;
    upd_valid = uv; upd_taken = ut; upd_pc = upc; upd_target = utg;
    li = int'(lpc[5:2]);
    e.hit = lv && m_v[li] && (m_tag[li] == lpc[31:6]);
    e.tgt = m_tgt[li];
    e.req = req;
    sb_q.push_back(e);
    if (uv) begin
      ui = int'(upc[5:2]);
      if (ut) begin
        m_v[ui] = 1'b1; m_tag[ui] = upc[31:6]; m_tgt[ui] = utg;
      end else if (m_v[ui] && m_tag[ui] == upc[31:6]) begin
        m_v[ui] = 1'b0;
      end
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(1'b1, pc, 1'b0, 1'b0, '0, '0, req);
  endtask

  // Monitor: pops expectations mid-cycle, after the lookup has settled.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (lk_hit !== e.hit) begin
          n_errors++;
          $display("FAIL %s: pc=%h hit=%b expected %b", e.req, lk_pc, lk_hit, e.hit);
        end else if (e.hit && lk_target !== e.tgt) begin
          n_errors++;
          $display("FAIL %s: pc=%h target=%h expected %h", e.req, lk_pc, lk_target, e.tgt);
        end
      end
    end
  end

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    logic [31:0] rs;
    for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: empty after reset
    look(32'h0000ac24, "R1");
    look(32'h00000000, "R1");
    look(32'h0000003c, "R1");
    // R8: write and lookup to entry 9 together -> old (empty) contents
    step(1'b1, 32'h0000ac24, 1'b1, 1'b1, 32'h0000ac24, 32'h0000ac48, "R8");
    look(32'h0000ac24, "R4");
    look(32'h0000ac27, "R2");
    look(32'h0000aca4, "R2");
    // R10: no lookup beat -> no hit
    step(1'b0, 32'h0000ac24, 1'b0, 1'b0, '0, '0, "R10");
    // R11: update fields wiggle with upd_valid low
    step(1'b0, 32'h0, 1'b0, 1'b1, 32'h0000aca4, 32'h00001234, "R11");
    step(1'b0, 32'h0, 1'b0, 1'b0, 32'h0000ac24, 32'h0, "R11");
    look(32'h0000ac24, "R11");
    // R7: not-taken with different tag on entry 9
    step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0000aca4, 32'h0, "R7");
    look(32'h0000ac24, "R7");
    // R5: eviction by other tag, same-cycle lookup sees old (R8)
    step(1'b1, 32'h0000ac24, 1'b1, 1'b1, 32'h0000aca4, 32'h0000acb8, "R8");
    look(32'h0000ac24, "R5");
    look(32'h0000aca4, "R4");
    // R9: write another index, entry 9 untouched
    step(1'b0, 32'h0, 1'b1, 1'b1, 32'h00001000, 32'h00002000, "R9");
    look(32'h0000aca4, "R9");
    look(32'h00001000, "R4");
    // R6: not-taken matching; same-cycle lookup still hits (R8)
    step(1'b1, 32'h0000aca4, 1'b1, 1'b0, 32'h0000aca4, 32'h0, "R8");
    look(32'h0000aca4, "R6");
    look(32'h00001000, "R9");
    // R9: fill all entries, then read all back
    for (int i = 0; i < 16; i++)
      step(1'b0, 32'h0, 1'b1, 1'b1, 32'h00030000 | (i << 2), 32'h00500000 + i, "R9");
    for (int i = 0; i < 16; i++)
      look(32'h00030000 | (i << 2), "R9");
    // R3: random mix over a small address pool
    rs = 32'h1ace_b00c;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      rs = lfsr_next(rs); a = {22'h00002b, rs[5:4], rs[3:0], 2'b00};
      rs = lfsr_next(rs); b = {22'h00002b, rs[7:6], rs[3:0], 2'b00};
      rs = lfsr_next(rs);
      step(rs[0] | rs[1], a, rs[2], rs[3] | rs[4], b, {16'h00f0, rs[15:0]}, "R3");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule